// File: doc/BRIEF.md
# UART Interrupt Identification and FIFO Control

This block collects the interrupt conditions of a UART receiver and transmitter, keeps one pending flag per source, and encodes the most urgent enabled source into a 4-bit identification code. The same code drives a single interrupt request line. Four sources are tracked: line status (overrun, or erroneous characters still held), receive data available, receive time-out, and transmitter empty. Each source is set and cleared by its own events, all taken from strobes and levels produced by the neighbouring receive and transmit datapaths.

The block also holds the write-only FIFO control register. That register shares its bus address with the read-only identification code, so a bus read at that address always returns `id_code` and a bus write always lands in the control register. The control register holds the FIFO-mode enable and the receive trigger selection. It also issues one-cycle clear pulses for the two FIFOs.

The receive time-out is kept by a three-state machine. `TO_IDLE` is entered whenever FIFO mode is off, the receiver is held in reset, or the receive FIFO is empty. Leaving `TO_IDLE` goes to `TO_COUNT`. `TO_COUNT` steps on each character-time tick while no character is pushed or popped. It moves to `TO_FIRED` on the tick that completes the idle window. `TO_FIRED` holds until a push or pop, which returns the machine to `TO_COUNT` with the count cleared, or until one of the `TO_IDLE` conditions returns.

Top module: `uart_irq_ident`

## Requirements
- R1: The identification code is 4'b0001 with nothing pending, 4'b0110 for line status, 4'b1100 for receive time-out, 4'b0100 for receive data available, and 4'b0010 for transmitter empty.
- R2: `irq` is high exactly when at least one enabled source is pending, and `id_code` shows the highest-ranked one. The ranking, highest first, is line status, time-out, data available, transmitter empty. Enables are `irq_en[2]` for line status, `irq_en[0]` for time-out and data available, and `irq_en[1]` for transmitter empty.
- R3: An `rx_overrun` pulse makes line status pending. A `lsr_rd` strobe clears it. If both occur in the same cycle, the overrun wins.
- R4: Line status is also pending while the count of erroneous characters held is nonzero. The count rises on `rx_push` with `rx_push_err` and falls on a pop with `rx_pop_err`. It never goes below zero and saturates at its maximum. A control write with bits 0 and 1 set clears it.
- R5: In FIFO mode, data available is pending while `rx_count` is at or above the trigger level. The level is taken from `trig_sel`: 0 gives 1, 1 gives a quarter of the depth, 2 gives half the depth, and 3 gives the depth minus 2.
- R6: Outside FIFO mode, data available is set by `rx_push` and cleared by a pop. If a push and a pop come together, the push wins.
- R7: In FIFO mode, with `rcv_run` high and `rx_count` nonzero, the time-out becomes pending after `TO_CHARS` character ticks with no push or pop.
- R8: A pending time-out is cleared by a push, by a pop, by `rcv_run` low, by an empty receive FIFO, or by FIFO mode being off.
- R9: Transmitter empty is set when `tx_empty` rises and cleared by `thr_wr`. If both occur in the same cycle, the write wins.
- R10: A control write with bit 0 set sets `fifo_en` and loads `trig_sel` from bits 7:6. In the following cycle it pulses `rx_fifo_clr` (if bit 1 is set) and `tx_fifo_clr` (if bit 2 is set). A control write with bit 0 clear only clears `fifo_en`: `trig_sel` keeps its value and no clear pulse is issued.
- R11: After reset, `fifo_en` is 0, `trig_sel` is 0, no clear pulse is active, all sources are idle, `id_code` is 4'b0001 and `irq` is 0.
- R12: A pop is `rbr_rd` or `dma_rd`, whichever comes first. Either one clears a time-out or a non-FIFO data-available flag. Both in one cycle count as a single pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_push | input | 1 | A received character enters the receive buffer or FIFO |
| rx_push_err | input | 1 | The pushed character has a parity, framing or break error |
| rbr_rd | input | 1 | CPU read pops a received character |
| dma_rd | input | 1 | DMA read pops a received character |
| rx_pop_err | input | 1 | The popped character was erroneous |
| rx_overrun | input | 1 | Receiver overrun pulse |
| lsr_rd | input | 1 | Read strobe of the line status register |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| char_tick | input | 1 | One-cycle strobe per character time |
| rcv_run | input | 1 | Receiver out of reset when 1 |
| tx_empty | input | 1 | Holding register or transmit FIFO empty |
| thr_wr | input | 1 | Write strobe to the transmit holding register |
| fcr_wr | input | 1 | Write strobe at the shared identification/control address |
| wdata | input | 8 | Write data for the control register |
| irq_en | input | 3 | Source enables: [0] receive data and time-out, [1] transmitter empty, [2] line status |
| id_code | output | 4 | Identification code |
| irq | output | 1 | Interrupt request |
| fifo_en | output | 1 | FIFO mode enabled |
| trig_sel | output | 2 | Receive trigger selection |
| rx_fifo_clr | output | 1 | One-cycle receive FIFO clear |
| tx_fifo_clr | output | 1 | One-cycle transmit FIFO clear |

## Verification
The encoder is driven with random mixes in which several sources are pending at once and the enables change, so that a wrong rank or a wrong mask shows up as a wrong code. One stretch runs outside FIFO mode, where data available follows push and pop edges and the control writes have bit 0 clear. Another runs in FIFO mode with sparse pushes and pops and dense ticks, so the time-out window completes often and is often broken by a push, a pop, an empty FIFO or a receiver reset. Directed sequences complete the window, then break it with a DMA pop and later with a push. A control write with bit 0 clear is also checked: it must leave the trigger selection as it was and issue no clear pulse.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    typedef enum logic [3:0] {
        ID_NONE    = 4'b0001,
        ID_LINE    = 4'b0110,
        ID_RXDATA  = 4'b0100,
        ID_TIMEOUT = 4'b1100,
        ID_TXEMPTY = 4'b0010
    } irq_id_e;

    typedef enum logic [1:0] {
        TO_IDLE  = 2'd0,
        TO_COUNT = 2'd1,
        TO_FIRED = 2'd2
    } to_state_e;

    typedef struct packed {
        logic line;
        logic timeout;
        logic rxdata;
        logic txempty;
    } irq_src_t;

    localparam int CTL_EN_BIT    = 0;
    localparam int CTL_RXCLR_BIT = 1;
    localparam int CTL_TXCLR_BIT = 2;
    localparam int CTL_TRIG_LSB  = 6;

endpackage

// File: rtl/uart_irq_fcr.sv
module uart_irq_fcr
    import uart_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fcr_wr,
    input  logic [7:0] wdata,
    output logic       fifo_en,
    output logic [1:0] trig_sel,
    output logic       rx_clr,
    output logic       tx_clr,
    output logic       rx_clr_req
);

    logic armed_wr;
    logic tx_clr_req;
    logic unused_ctl_bits;

    assign armed_wr        = fcr_wr && wdata[CTL_EN_BIT];
    assign rx_clr_req      = armed_wr && wdata[CTL_RXCLR_BIT];
    assign tx_clr_req      = armed_wr && wdata[CTL_TXCLR_BIT];
    assign unused_ctl_bits = ^wdata[5:3];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fifo_en  <= 1'b0;
            trig_sel <= 2'd0;
            rx_clr   <= 1'b0;
            tx_clr   <= 1'b0;
        end else begin
            rx_clr <= rx_clr_req;
            tx_clr <= tx_clr_req;
            if (fcr_wr) begin
                fifo_en <= wdata[CTL_EN_BIT];
            end
            if (armed_wr) begin
                trig_sel <= wdata[CTL_TRIG_LSB +: 2];
            end
        end
    end

endmodule

// File: rtl/uart_irq_timeout.sv
module uart_irq_timeout
    import uart_irq_pkg::*;
#(
    parameter int TO_CHARS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic activity,
    input  logic tick,
    output logic fired
);

    localparam int CW = $clog2(TO_CHARS + 1);
    localparam logic [CW-1:0] LAST = CW'(TO_CHARS - 1);

    to_state_e     state, state_nx;
    logic [CW-1:0] cnt, cnt_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TO_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        if (!armed) begin
            state_nx = TO_IDLE;
            cnt_nx   = '0;
        end else if (activity) begin
            state_nx = TO_COUNT;
            cnt_nx   = '0;
        end else begin
            unique case (state)
                TO_IDLE, TO_COUNT: begin
                    if (tick) begin
                        cnt_nx   = cnt + 1'b1;
                        state_nx = (cnt == LAST) ? TO_FIRED : TO_COUNT;
                    end else begin
                        state_nx = TO_COUNT;
                    end
                end
                TO_FIRED: begin
                    state_nx = TO_FIRED;
                end
                default: begin
                    state_nx = TO_IDLE;
                    cnt_nx   = '0;
                end
            endcase
        end
    end

    always_comb begin
        fired = (state == TO_FIRED);
    end

endmodule

// File: rtl/uart_irq_src.sv
module uart_irq_src #(
    parameter int FIFO_DEPTH = 16,
    parameter int ERR_W      = 5,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic [1:0]       trig_sel,
    input  logic             rx_push,
    input  logic             rx_push_err,
    input  logic             rx_pop,
    input  logic             rx_pop_err,
    input  logic             rx_overrun,
    input  logic             lsr_rd,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             rx_clr_req,
    input  logic             tx_empty,
    input  logic             thr_wr,
    output logic             line_pend,
    output logic             rxdata_pend,
    output logic             txempty_pend
);

    localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};

    logic             ovr_flag;
    logic [ERR_W-1:0] err_cnt;
    logic             nf_ready;
    logic             thre_flag;
    logic             tx_empty_q;
    logic             err_up, err_dn;
    logic [CNT_W-1:0] trig_level;

    always_comb begin
        unique case (trig_sel)
            2'd0:    trig_level = CNT_W'(1);
            2'd1:    trig_level = CNT_W'(FIFO_DEPTH / 4);
            2'd2:    trig_level = CNT_W'(FIFO_DEPTH / 2);
            default: trig_level = CNT_W'(FIFO_DEPTH - 2);
        endcase
    end

    assign err_up = rx_push && rx_push_err;
    assign err_dn = rx_pop && rx_pop_err && (err_cnt != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovr_flag <= 1'b0;
        end else if (rx_overrun) begin
            ovr_flag <= 1'b1;
        end else if (lsr_rd) begin
            ovr_flag <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_cnt <= '0;
        end else if (rx_clr_req) begin
            err_cnt <= '0;
        end else if (err_up && !err_dn && err_cnt != ERR_MAX) begin
            err_cnt <= err_cnt + 1'b1;
        end else if (err_dn && !err_up) begin
            err_cnt <= err_cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nf_ready <= 1'b0;
        end else if (rx_push) begin
            nf_ready <= 1'b1;
        end else if (rx_pop) begin
            nf_ready <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thre_flag  <= 1'b0;
            tx_empty_q <= 1'b0;
        end else begin
            tx_empty_q <= tx_empty;
            if (thr_wr) begin
                thre_flag <= 1'b0;
            end else if (tx_empty && !tx_empty_q) begin
                thre_flag <= 1'b1;
            end
        end
    end

    assign line_pend    = ovr_flag || (err_cnt != '0);
    assign rxdata_pend  = fifo_en ? (rx_count >= trig_level) : nf_ready;
    assign txempty_pend = thre_flag;

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  irq_src_t pend,
    output irq_id_e  id,
    output logic     irq
);

    always_comb begin
        if (pend.line) begin
            id = ID_LINE;
        end else if (pend.timeout) begin
            id = ID_TIMEOUT;
        end else if (pend.rxdata) begin
            id = ID_RXDATA;
        end else if (pend.txempty) begin
            id = ID_TXEMPTY;
        end else begin
            id = ID_NONE;
        end
        irq = |pend;
    end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int TO_CHARS   = 4,
    parameter int ERR_W      = 5,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_push,
    input  logic             rx_push_err,
    input  logic             rbr_rd,
    input  logic             dma_rd,
    input  logic             rx_pop_err,
    input  logic             rx_overrun,
    input  logic             lsr_rd,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             char_tick,
    input  logic             rcv_run,
    input  logic             tx_empty,
    input  logic             thr_wr,
    input  logic             fcr_wr,
    input  logic [7:0]       wdata,
    input  logic [2:0]       irq_en,
    output logic [3:0]       id_code,
    output logic             irq,
    output logic             fifo_en,
    output logic [1:0]       trig_sel,
    output logic             rx_fifo_clr,
    output logic             tx_fifo_clr
);

    logic     rx_pop;
    logic     rx_clr_req;
    logic     line_pend, rxdata_pend, txempty_pend;
    logic     to_armed, to_fired;
    irq_src_t masked;
    irq_id_e  id_enc;

    assign rx_pop   = rbr_rd || dma_rd;
    assign to_armed = fifo_en && rcv_run && (rx_count != '0);

    uart_irq_fcr u_fcr (
        .clk        (clk),
        .rst_n      (rst_n),
        .fcr_wr     (fcr_wr),
        .wdata      (wdata),
        .fifo_en    (fifo_en),
        .trig_sel   (trig_sel),
        .rx_clr     (rx_fifo_clr),
        .tx_clr     (tx_fifo_clr),
        .rx_clr_req (rx_clr_req)
    );

    uart_irq_src #(
        .FIFO_DEPTH (FIFO_DEPTH),
        .ERR_W      (ERR_W)
    ) u_src (
        .clk          (clk),
        .rst_n        (rst_n),
        .fifo_en      (fifo_en),
        .trig_sel     (trig_sel),
        .rx_push      (rx_push),
        .rx_push_err  (rx_push_err),
        .rx_pop       (rx_pop),
        .rx_pop_err   (rx_pop_err),
        .rx_overrun   (rx_overrun),
        .lsr_rd       (lsr_rd),
        .rx_count     (rx_count),
        .rx_clr_req   (rx_clr_req),
        .tx_empty     (tx_empty),
        .thr_wr       (thr_wr),
        .line_pend    (line_pend),
        .rxdata_pend  (rxdata_pend),
        .txempty_pend (txempty_pend)
    );

    uart_irq_timeout #(
        .TO_CHARS (TO_CHARS)
    ) u_to (
        .clk      (clk),
        .rst_n    (rst_n),
        .armed    (to_armed),
        .activity (rx_push || rx_pop),
        .tick     (char_tick),
        .fired    (to_fired)
    );

    always_comb begin
        masked.line    = line_pend    && irq_en[2];
        masked.timeout = to_fired     && irq_en[0];
        masked.rxdata  = rxdata_pend  && irq_en[0];
        masked.txempty = txempty_pend && irq_en[1];
    end

    uart_irq_prio u_prio (
        .pend (masked),
        .id   (id_enc),
        .irq  (irq)
    );

    assign id_code = id_enc;

endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_overrun,
    input logic       rx_push,
    input logic [2:0] irq_en,
    input logic       fcr_wr,
    input logic [7:0] wdata,
    input logic [3:0] id_code,
    input logic       irq,
    input logic       fifo_en,
    input logic [1:0] trig_sel,
    input logic       rx_fifo_clr,
    input logic       tx_fifo_clr
);

    AST_ID_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        id_code inside {4'b0001, 4'b0110, 4'b0100, 4'b1100, 4'b0010}); // R1

    AST_QUIET_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> id_code == 4'b0001); // R2

    AST_ACTIVE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> id_code != 4'b0001); // R2

    AST_OVERRUN_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |=> (!irq_en[2] || id_code == 4'b0110)); // R3

    AST_PUSH_ENDS_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |=> id_code != 4'b1100); // R8

    AST_RXCLR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (fcr_wr && wdata[0] && wdata[1]) |=> (rx_fifo_clr && fifo_en)); // R10

    AST_UNARMED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (fcr_wr && !wdata[0]) |=> (!fifo_en && !rx_fifo_clr && !tx_fifo_clr && $stable(trig_sel))); // R10

endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (.*);

// File: tb/sim_uart_irq_ident.sv
module sim_uart_irq_ident;

    localparam int CLK_P      = 10;
    localparam int FIFO_DEPTH = 16;
    localparam int TO_N       = 4;
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1);
    localparam int ERR_TOP    = 31;

    logic             clk, rst_n;
    logic             rx_push, rx_push_err, rbr_rd, dma_rd, rx_pop_err;
    logic             rx_overrun, lsr_rd, char_tick, rcv_run;
    logic [CNT_W-1:0] rx_count;
    logic             tx_empty, thr_wr, fcr_wr;
    logic [7:0]       wdata;
    logic [2:0]       irq_en;
    logic [3:0]       id_code;
    logic             irq, fifo_en, rx_fifo_clr, tx_fifo_clr;
    logic [1:0]       trig_sel;

    int n_chk = 0;
    int n_err = 0;
    bit cmp_on = 0;

    // reference state
    int m_ovr, m_err, m_nfdr, m_thre, m_prev, m_to, m_fen, m_trig, m_rxclr, m_txclr;

    uart_irq_ident u0 (
        .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_push_err(rx_push_err),
        .rbr_rd(rbr_rd), .dma_rd(dma_rd), .rx_pop_err(rx_pop_err),
        .rx_overrun(rx_overrun), .lsr_rd(lsr_rd), .rx_count(rx_count),
        .char_tick(char_tick), .rcv_run(rcv_run), .tx_empty(tx_empty),
        .thr_wr(thr_wr), .fcr_wr(fcr_wr), .wdata(wdata), .irq_en(irq_en),
        .id_code(id_code), .irq(irq), .fifo_en(fifo_en), .trig_sel(trig_sel),
        .rx_fifo_clr(rx_fifo_clr), .tx_fifo_clr(tx_fifo_clr)
    );

    initial clk = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    function automatic int trig_lvl(input int s);
        case (s)
            0:       return 1;
            1:       return FIFO_DEPTH / 4;
            2:       return FIFO_DEPTH / 2;
            default: return FIFO_DEPTH - 2;
        endcase
    endfunction

    // reference model, updated on every rising edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ovr = 0; m_err = 0; m_nfdr = 0; m_thre = 0; m_prev = 0;
            m_to = 0; m_fen = 0; m_trig = 0; m_rxclr = 0; m_txclr = 0;
        end else begin
            m_rxclr = (fcr_wr && wdata[0] && wdata[1]) ? 1 : 0;
            m_txclr = (fcr_wr && wdata[0] && wdata[2]) ? 1 : 0;
            if (rx_overrun) m_ovr = 1;
            else if (lsr_rd) m_ovr = 0;
            if (m_rxclr == 1) m_err = 0;
            else begin
                if (rx_push && rx_push_err && !((rbr_rd || dma_rd) && rx_pop_err && m_err > 0)) begin
                    if (m_err < ERR_TOP) m_err++;
                end else if (!(rx_push && rx_push_err) && (rbr_rd || dma_rd) && rx_pop_err && m_err > 0)
                    m_err--;
            end
            if (rx_push) m_nfdr = 1;
            else if (rbr_rd || dma_rd) m_nfdr = 0;
            if (!(m_fen == 1 && rcv_run && rx_count != 0)) m_to = 0;
            else if (rx_push || rbr_rd || dma_rd) m_to = 0;
            else if (char_tick && m_to < TO_N) m_to++;
            if (thr_wr) m_thre = 0;
            else if (tx_empty && m_prev == 0) m_thre = 1;
            m_prev = tx_empty ? 1 : 0;
            if (fcr_wr) begin
                if (wdata[0]) begin
                    m_fen  = 1;
                    m_trig = int'(wdata[7:6]);
                end else begin
                    m_fen = 0;
                end
            end
        end
    end

    // comparison on every falling edge
    always @(negedge clk) begin : cmp
        int e_id, e_irq, dr;
        string tag;
        if (rst_n && cmp_on) begin
            dr = (m_fen == 1) ? ((int'(rx_count) >= trig_lvl(m_trig)) ? 1 : 0) : m_nfdr;
            e_id = 1; e_irq = 1; tag = "R2 none";
            if ((m_ovr == 1 || m_err != 0) && irq_en[2]) begin
                e_id = 6; tag = (m_ovr == 1) ? "R1 R3 line" : "R1 R4 line";
            end else if (m_to == TO_N && irq_en[0]) begin
                e_id = 12; tag = "R1 R7 timeout";
            end else if (dr == 1 && irq_en[0]) begin
                e_id = 4; tag = (m_fen == 1) ? "R1 R5 rxdata" : "R1 R6 rxdata";
            end else if (m_thre == 1 && irq_en[1]) begin
                e_id = 2; tag = "R1 R9 txempty";
            end else begin
                e_irq = 0;
            end
            chk(tag, int'(id_code), e_id);
            chk("R2 irq", int'(irq), e_irq);
            chk("R10 fifo_en", int'(fifo_en), m_fen);
            chk("R10 trig_sel", int'(trig_sel), m_trig);
            chk("R10 rx_fifo_clr", int'(rx_fifo_clr), m_rxclr);
            chk("R10 tx_fifo_clr", int'(tx_fifo_clr), m_txclr);
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        rx_push = 0; rx_push_err = 0; rbr_rd = 0; dma_rd = 0; rx_pop_err = 0;
        rx_overrun = 0; lsr_rd = 0; char_tick = 0; thr_wr = 0; fcr_wr = 0;
        wdata = 8'h00;
    endtask

    task automatic rnd(input int p_act, input int p_tick, input int fcr_mode);
        rx_push     = ($urandom_range(0, 99) < p_act);
        rx_push_err = ($urandom_range(0, 9) == 0);
        rbr_rd      = ($urandom_range(0, 99) < p_act);
        dma_rd      = ($urandom_range(0, 99) < p_act / 2);
        rx_pop_err  = ($urandom_range(0, 4) == 0);
        rx_overrun  = ($urandom_range(0, 99) < 2);
        lsr_rd      = ($urandom_range(0, 99) < 6);
        if ($urandom_range(0, 99) < 15) rx_count = CNT_W'($urandom_range(0, FIFO_DEPTH));
        char_tick   = ($urandom_range(0, 99) < p_tick);
        rcv_run     = ($urandom_range(0, 99) != 0);
        if ($urandom_range(0, 99) < 10) tx_empty = ~tx_empty;
        thr_wr      = ($urandom_range(0, 99) < 5);
        if ($urandom_range(0, 99) < 5) irq_en = 3'($urandom_range(0, 7));
        fcr_wr      = (fcr_mode != 0) && ($urandom_range(0, 99) < 4);
        wdata       = 8'($urandom_range(0, 255));
        if (fcr_mode == 1) wdata[0] = 1'b0;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired at %0t", $time);
        finish_run();
    end

    initial begin
        rst_n = 0;
        idle_inputs();
        rcv_run = 1; tx_empty = 0; irq_en = 3'b000; rx_count = '0;
        repeat (3) step();
        rst_n = 1;
        step();
        // R11: reset state
        chk("R11 id_code", int'(id_code), 1);
        chk("R11 irq", int'(irq), 0);
        chk("R11 fifo_en", int'(fifo_en), 0);
        chk("R11 trig_sel", int'(trig_sel), 0);
        chk("R11 clr pulses", int'(rx_fifo_clr) + int'(tx_fifo_clr), 0);
        cmp_on = 1;

        // non-FIFO mode, control writes never arm the register
        for (int i = 0; i < 600; i++) begin rnd(20, 10, 1); step(); end
        idle_inputs();

        // directed time-out window in FIFO mode (R7, R8, R12)
        irq_en = 3'b001; rx_count = CNT_W'(2); rcv_run = 1;
        fcr_wr = 1; wdata = 8'hC1; step();
        fcr_wr = 0; wdata = 8'h00; step();
        chk("R10 armed write trig", int'(trig_sel), 3);
        char_tick = 1;
        repeat (TO_N) step();
        char_tick = 0;
        chk("R7 timeout code", int'(id_code), 12);
        dma_rd = 1; rx_count = CNT_W'(1); step();
        dma_rd = 0;
        chk("R12 dma pop clears timeout", int'(id_code), 1);
        char_tick = 1;
        repeat (TO_N - 1) step();
        char_tick = 0;
        chk("R7 window not complete", int'(id_code), 1);
        char_tick = 1; step(); char_tick = 0;
        chk("R7 timeout after window", int'(id_code), 12);
        rx_push = 1; rx_count = CNT_W'(2); step();
        rx_push = 0;
        chk("R8 push clears timeout", int'(id_code), 1);
        char_tick = 1; repeat (TO_N) step(); char_tick = 0;
        rcv_run = 0; step();
        chk("R8 receiver reset clears timeout", int'(id_code), 1);
        rcv_run = 1;

        // unarmed write leaves trigger selection and issues no pulse (R10)
        fcr_wr = 1; wdata = 8'h46; step();
        fcr_wr = 0;
        chk("R10 unarmed fifo_en", int'(fifo_en), 0);
        chk("R10 unarmed trig kept", int'(trig_sel), 3);
        chk("R10 unarmed no pulse", int'(rx_fifo_clr) + int'(tx_fifo_clr), 0);
        fcr_wr = 1; wdata = 8'h47; step();
        fcr_wr = 0;
        chk("R10 armed rx clear", int'(rx_fifo_clr), 1);
        chk("R10 armed tx clear", int'(tx_fifo_clr), 1);
        chk("R10 armed trig", int'(trig_sel), 1);
        step();

        // FIFO mode, sparse activity and dense ticks
        for (int i = 0; i < 2500; i++) begin rnd(4, 60, 0); step(); end
        // FIFO mode with armed control writes
        idle_inputs();
        fcr_wr = 1; wdata = 8'h81; step();
        for (int i = 0; i < 2500; i++) begin rnd(10, 40, 2); if (fcr_wr) wdata[0] = 1'b1; step(); end
        // mixed, writes may enable or disable FIFO mode
        for (int i = 0; i < 3000; i++) begin rnd(8, 50, 2); step(); end

        idle_inputs();
        step();
        finish_run();
    end

endmodule